// File: doc/BRIEF.md
# Bus Cycle Strobe Decoder

This block sits between a processor's time-multiplexed 16-bit information bus and the memory and peripheral side of the system. During the address phase an active-high address strobe latches the bus word, and the latched value stays on the address outputs for the rest of the cycle. During the data phase an active-low data strobe, together with the memory/I-O qualifier and the read/write qualifier, selects one of four active-low strobes: memory read, memory write, I/O read or I/O write.

A few I/O addresses are decoded inside the block. An I/O write to 0x1000 also pulses an interrupt-acknowledge strobe. An I/O read from 0x8410 returns five configuration inputs on the bus and pulses a configuration-read output. I/O writes to two parameter-set addresses set or clear a start-up ROM enable flag. A DMA master can take the bus through an active-low strobe-enable input. Each of two control bits decides whether the address outputs or the strobe outputs go to high impedance, which the block reports through output-enable signals.

Top module: `bus_strobe_decoder`

## Requirements
- R1: When `addr_stb` is 1 at a rising clock edge, `addr_out` takes the value of `ib_in` after that edge. At all other edges `addr_out` keeps its value. Reset clears it to 0.
- R2: While `data_stb_n` is 0 and `is_mem` is 1, `mem_rd_n` is 0 when `rd_wr` is 1 (read) and `mem_wr_n` is 0 when `rd_wr` is 0 (write). Otherwise both are 1. Both follow the inputs within the same cycle.
- R3: While `data_stb_n` is 0 and `is_mem` is 0, `io_rd_n` or `io_wr_n` goes to 0 according to `rd_wr`. The exception is a latched address equal to the configuration address or to either ROM command address: then both stay 1.
- R4: At most one of the four bus strobes is 0 at any time. All four are 1 while `data_stb_n` is 1.
- R5: `int_ack_n` is 0 exactly while an I/O write to latched address 0x1000 is in its data phase. `io_wr_n` is 0 at the same time.
- R6: During an I/O read from latched address 0x8410 with `data_stb_n` at 0, `cfg_rd_n` is 0, `ib_oe` is 1, and `ib_out` bits 4..0 equal `cfg_in` while bits 15..5 are 0.
- R7: `ib_oe` is 0 whenever no configuration read is in its data phase.
- R8: An I/O write to latched address `ROM_ON_ADDR` (default 0x4000) during the data phase sets `rom_en` to 1 at the next clock edge. A write to `ROM_OFF_ADDR` (default 0x4001) clears it to 0. Any other cycle leaves it unchanged.
- R9: During and directly after reset, `rom_en` is 1, `addr_out` is 0 and all strobes are 1.
- R10: `addr_oe` is 0 exactly when `strb_en_n` is 1 and `float_addr` is 1. `strb_oe` is 0 exactly when `strb_en_n` is 1 and `float_strb` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_stb | input | 1 | Address strobe, active high |
| data_stb_n | input | 1 | Data strobe, active low |
| is_mem | input | 1 | Cycle qualifier: 1 memory, 0 I/O |
| rd_wr | input | 1 | Cycle qualifier: 1 read, 0 write |
| ib_in | input | 16 | Information bus, inbound value |
| cfg_in | input | 5 | System configuration inputs |
| strb_en_n | input | 1 | Strobe enable, active low; 1 requests bus release |
| float_addr | input | 1 | Control bit allowing release of address outputs |
| float_strb | input | 1 | Control bit allowing release of the bus strobes |
| ib_out | output | 16 | Information bus, outbound value |
| ib_oe | output | 1 | Drive enable for `ib_out` |
| addr_out | output | 16 | Latched cycle address |
| addr_oe | output | 1 | Drive enable for `addr_out` |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| strb_oe | output | 1 | Drive enable for the four bus strobes |
| int_ack_n | output | 1 | Interrupt acknowledge strobe |
| cfg_rd_n | output | 1 | Configuration read strobe |
| rom_en | output | 1 | Start-up ROM enable flag |

## Verification
The hardest case to reach is the one where the latched address has to survive the data phase. All decoding depends on the address held from the address phase, not on the bus word present while the data strobe is low. The stimulus therefore drives random values onto `ib_in` during every data phase, so a latch that leaks the live bus would decode the wrong address. Random cycles are biased toward the special addresses, so ROM set and clear commands arrive in many orders, including repeats. A bench model of the flag follows these commands and checks `rom_en` after each one.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_MEM_RD,
        CYC_MEM_WR,
        CYC_IO_RD,
        CYC_IO_WR
    } cyc_kind_e;

    function automatic cyc_kind_e classify(input logic ds_n, input logic mem, input logic rd);
        cyc_kind_e k;
        if (ds_n)          k = CYC_IDLE;
        else if (mem &&  rd) k = CYC_MEM_RD;
        else if (mem && !rd) k = CYC_MEM_WR;
        else if (rd)         k = CYC_IO_RD;
        else                 k = CYC_IO_WR;
        return k;
    endfunction

endpackage

// File: rtl/addr_latch.sv
module addr_latch #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [AW-1:0] bus_in,
    output logic [AW-1:0] addr
);
    typedef struct packed {
        logic [AW-1:0] addr;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) st_d.addr = bus_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr = st_q.addr;

    // R1
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> addr == $past(addr));
    // R1
    latch_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> addr == $past(bus_in));
endmodule

// File: rtl/special_decode.sv
module special_decode #(
    parameter int            AW        = 16,
    parameter logic [AW-1:0] INTA_ADDR = 16'h1000,
    parameter logic [AW-1:0] CFG_ADDR  = 16'h8410,
    parameter logic [AW-1:0] ON_ADDR   = 16'h4000,
    parameter logic [AW-1:0] OFF_ADDR  = 16'h4001
) (
    input  logic [AW-1:0] addr,
    output logic          hit_inta,
    output logic          hit_cfg,
    output logic          hit_on,
    output logic          hit_off,
    output logic          internal
);
    always_comb begin
        hit_inta = (addr == INTA_ADDR);
        hit_cfg  = (addr == CFG_ADDR);
        hit_on   = (addr == ON_ADDR);
        hit_off  = (addr == OFF_ADDR);
        internal = hit_cfg | hit_on | hit_off;
    end
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
    import bsd_pkg::*;
#(
    parameter int AW   = 16,
    parameter int CFGW = 5
) (
    input  logic            ds_n,
    input  logic            is_mem,
    input  logic            rd_wr,
    input  logic            hit_inta,
    input  logic            hit_cfg,
    input  logic            hit_on,
    input  logic            hit_off,
    input  logic            internal,
    input  logic [CFGW-1:0] cfg_in,
    output logic            mem_rd_n,
    output logic            mem_wr_n,
    output logic            io_rd_n,
    output logic            io_wr_n,
    output logic            inta_n,
    output logic            cfg_n,
    output logic [AW-1:0]   bus_out,
    output logic            bus_oe,
    output logic            rom_set,
    output logic            rom_clr
);
    cyc_kind_e kind;
    logic      cfg_rd;

    always_comb begin
        kind     = classify(ds_n, is_mem, rd_wr);
        cfg_rd   = (kind == CYC_IO_RD) && hit_cfg;
        mem_rd_n = !(kind == CYC_MEM_RD);
        mem_wr_n = !(kind == CYC_MEM_WR);
        io_rd_n  = !((kind == CYC_IO_RD) && !internal);
        io_wr_n  = !((kind == CYC_IO_WR) && !internal);
        inta_n   = !((kind == CYC_IO_WR) && hit_inta);
        cfg_n    = !cfg_rd;
        bus_oe   = cfg_rd;
        rom_set  = (kind == CYC_IO_WR) && hit_on;
        rom_clr  = (kind == CYC_IO_WR) && hit_off;
    end

    for (genvar i = 0; i < AW; i++) begin : g_bus
        if (i < CFGW) begin : g_cfg
            assign bus_out[i] = cfg_rd & cfg_in[i];
        end else begin : g_zero
            assign bus_out[i] = 1'b0;
        end
    end
endmodule

// File: rtl/rom_flag.sv
module rom_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic on;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set)      st_d.on = 1'b1;
        else if (clr) st_d.on = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{on: 1'b1};
        else        st_q <= st_d;
    end

    assign flag = st_q.on;

    // R8
    rom_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(set));
    // R8
    rom_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr));
endmodule

// File: rtl/bus_strobe_decoder.sv
module bus_strobe_decoder #(
    parameter int              AW           = 16,
    parameter int              CFGW         = 5,
    parameter logic [AW-1:0]   INTA_ADDR    = 16'h1000,
    parameter logic [AW-1:0]   CFG_ADDR     = 16'h8410,
    parameter logic [AW-1:0]   ROM_ON_ADDR  = 16'h4000,
    parameter logic [AW-1:0]   ROM_OFF_ADDR = 16'h4001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_stb,
    input  logic            data_stb_n,
    input  logic            is_mem,
    input  logic            rd_wr,
    input  logic [AW-1:0]   ib_in,
    input  logic [CFGW-1:0] cfg_in,
    input  logic            strb_en_n,
    input  logic            float_addr,
    input  logic            float_strb,
    output logic [AW-1:0]   ib_out,
    output logic            ib_oe,
    output logic [AW-1:0]   addr_out,
    output logic            addr_oe,
    output logic            mem_rd_n,
    output logic            mem_wr_n,
    output logic            io_rd_n,
    output logic            io_wr_n,
    output logic            strb_oe,
    output logic            int_ack_n,
    output logic            cfg_rd_n,
    output logic            rom_en
);
    logic hit_inta, hit_cfg, hit_on, hit_off, internal;
    logic rom_set, rom_clr;

    addr_latch #(.AW(AW)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (addr_stb),
        .bus_in  (ib_in),
        .addr    (addr_out)
    );

    special_decode #(
        .AW(AW), .INTA_ADDR(INTA_ADDR), .CFG_ADDR(CFG_ADDR),
        .ON_ADDR(ROM_ON_ADDR), .OFF_ADDR(ROM_OFF_ADDR)
    ) u_dec (
        .addr     (addr_out),
        .hit_inta (hit_inta),
        .hit_cfg  (hit_cfg),
        .hit_on   (hit_on),
        .hit_off  (hit_off),
        .internal (internal)
    );

    strobe_gen #(.AW(AW), .CFGW(CFGW)) u_stb (
        .ds_n     (data_stb_n),
        .is_mem   (is_mem),
        .rd_wr    (rd_wr),
        .hit_inta (hit_inta),
        .hit_cfg  (hit_cfg),
        .hit_on   (hit_on),
        .hit_off  (hit_off),
        .internal (internal),
        .cfg_in   (cfg_in),
        .mem_rd_n (mem_rd_n),
        .mem_wr_n (mem_wr_n),
        .io_rd_n  (io_rd_n),
        .io_wr_n  (io_wr_n),
        .inta_n   (int_ack_n),
        .cfg_n    (cfg_rd_n),
        .bus_out  (ib_out),
        .bus_oe   (ib_oe),
        .rom_set  (rom_set),
        .rom_clr  (rom_clr)
    );

    rom_flag u_rom (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (rom_set),
        .clr   (rom_clr),
        .flag  (rom_en)
    );

    always_comb begin
        addr_oe = !(strb_en_n && float_addr);
        strb_oe = !(strb_en_n && float_strb);
    end

    // R4
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~{mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}));
    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb_n |-> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n && int_ack_n && cfg_rd_n));
    // R6
    cfg_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ib_oe |-> (!cfg_rd_n && io_rd_n && (ib_out >> CFGW) == '0));
    // R5
    inta_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_ack_n |-> !io_wr_n);
    // R10
    no_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_en_n |-> (addr_oe && strb_oe));
endmodule

// File: tb/bus_strobe_decoder_bench.sv
module bus_strobe_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_stb = 1'b0;
    logic        data_stb_n = 1'b1;
    logic        is_mem = 1'b0;
    logic        rd_wr = 1'b0;
    logic [15:0] ib_in = '0;
    logic [4:0]  cfg_in = '0;
    logic        strb_en_n = 1'b0;
    logic        float_addr = 1'b0;
    logic        float_strb = 1'b0;
    logic [15:0] ib_out, addr_out;
    logic        ib_oe, addr_oe, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
    logic        strb_oe, int_ack_n, cfg_rd_n, rom_en;

    int n_tests = 0;
    int n_fail  = 0;
    logic rom_model = 1'b1;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    bus_strobe_decoder u_bus_strobe_decoder (
        .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .data_stb_n(data_stb_n),
        .is_mem(is_mem), .rd_wr(rd_wr), .ib_in(ib_in), .cfg_in(cfg_in),
        .strb_en_n(strb_en_n), .float_addr(float_addr), .float_strb(float_strb),
        .ib_out(ib_out), .ib_oe(ib_oe), .addr_out(addr_out), .addr_oe(addr_oe),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .strb_oe(strb_oe), .int_ack_n(int_ack_n), .cfg_rd_n(cfg_rd_n), .rom_en(rom_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, int_ack_n, cfg_rd_n}
    function automatic logic [5:0] exp_strobes(input logic [15:0] a, input logic m, input logic r);
        logic intern = (a == 16'h8410) || (a == 16'h4000) || (a == 16'h4001);
        logic [5:0] v = 6'b111111;
        if (m &&  r) v[5] = 1'b0;
        if (m && !r) v[4] = 1'b0;
        if (!m &&  r && !intern) v[3] = 1'b0;
        if (!m && !r && !intern) v[2] = 1'b0;
        if (!m && !r && a == 16'h1000) v[1] = 1'b0;
        if (!m &&  r && a == 16'h8410) v[0] = 1'b0;
        return v;
    endfunction

    function automatic logic [15:0] exp_bus(input logic [15:0] a, input logic m, input logic r,
                                            input logic [4:0] c);
        return (!m && r && a == 16'h8410) ? {11'b0, c} : 16'h0000;
    endfunction

    task automatic bus_cycle(input logic [15:0] a, input logic m, input logic r, input logic [4:0] c);
        logic [15:0] eb;
        @(negedge clk);
        addr_stb = 1'b1; ib_in = a;
        @(negedge clk);
        addr_stb = 1'b0; ib_in = 16'($urandom); is_mem = m; rd_wr = r; cfg_in = c;
        data_stb_n = 1'b0;
        #1;
        check("R1 latched address", 32'(addr_out), 32'(a));
        check("R2/R3/R5/R6 strobes", 32'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, int_ack_n, cfg_rd_n}),
              32'(exp_strobes(a, m, r)));
        eb = exp_bus(a, m, r, c);
        check("R6/R7 bus enable", 32'(ib_oe), 32'(eb != 16'h0 || (!m && r && a == 16'h8410)));
        if (ib_oe) check("R6 bus value", 32'(ib_out), 32'(eb));
        if (!m && !r && a == 16'h4000) rom_model = 1'b1;
        if (!m && !r && a == 16'h4001) rom_model = 1'b0;
        @(negedge clk);
        check("R8 rom flag", 32'(rom_en), 32'(rom_model));
        data_stb_n = 1'b1;
        #1;
        check("R4 idle strobes", 32'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, int_ack_n, cfg_rd_n}), 32'h3f);
        check("R7 bus idle", 32'(ib_oe), 32'd0);
        check("R1 hold after strobe", 32'(addr_out), 32'(a));
    endtask

    task automatic release_check(input logic e, input logic fa, input logic fs);
        @(negedge clk);
        strb_en_n = e; float_addr = fa; float_strb = fs;
        #1;
        check("R10 addr_oe", 32'(addr_oe), 32'(!(e && fa)));
        check("R10 strb_oe", 32'(strb_oe), 32'(!(e && fs)));
    endtask

    initial begin
        void'($urandom(32'd1754));
        repeat (3) @(negedge clk);
        // R9 values during reset
        check("R9 rom in reset", 32'(rom_en), 32'd1);
        check("R9 addr in reset", 32'(addr_out), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 rom after reset", 32'(rom_en), 32'd1);
        check("R9 addr after reset", 32'(addr_out), 32'd0);
        check("R9 strobes after reset",
              32'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, int_ack_n, cfg_rd_n}), 32'h3f);

        // directed corners
        bus_cycle(16'h1234, 1'b1, 1'b1, 5'h00);   // R2 read
        bus_cycle(16'hfffe, 1'b1, 1'b0, 5'h00);   // R2 write
        bus_cycle(16'h0042, 1'b0, 1'b1, 5'h00);   // R3 read
        bus_cycle(16'h0043, 1'b0, 1'b0, 5'h00);   // R3 write
        bus_cycle(16'h1000, 1'b0, 1'b0, 5'h00);   // R5
        bus_cycle(16'h1000, 1'b0, 1'b1, 5'h00);   // R5: read gives no ack
        bus_cycle(16'h8410, 1'b0, 1'b1, 5'h15);   // R6
        bus_cycle(16'h8410, 1'b0, 1'b1, 5'h1f);   // R6
        bus_cycle(16'h8410, 1'b1, 1'b1, 5'h1f);   // R7 memory read at that address
        bus_cycle(16'h4001, 1'b0, 1'b0, 5'h00);   // R8 clear
        bus_cycle(16'h4001, 1'b0, 1'b0, 5'h00);   // R8 clear again
        bus_cycle(16'h4000, 1'b1, 1'b0, 5'h00);   // R8 memory write leaves flag
        bus_cycle(16'h4000, 1'b0, 1'b1, 5'h00);   // R8 read leaves flag
        bus_cycle(16'h4000, 1'b0, 1'b0, 5'h00);   // R8 set
        for (int i = 0; i < 8; i++) release_check(i[2], i[1], i[0]);  // R10

        // random traffic biased toward special addresses
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            case ($urandom_range(0, 5))
                0: a = 16'h1000;
                1: a = 16'h8410;
                2: a = 16'h4000;
                3: a = 16'h4001;
                default: a = 16'($urandom);
            endcase
            bus_cycle(a, 1'($urandom), 1'($urandom), 5'($urandom));
            if (i % 10 == 0)
                release_check(1'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule